// File: doc/BRIEF.md
# Cache Line-Fill Controller with Bus Backoff

This block is the processor-side bus sequencer that brings a 16-byte cache line in from memory as four doubleword transfers. A fill begins from a requested doubleword and walks the line in interleaved burst order. The system may answer each transfer with a burst ready, which keeps the cycle open, or with a non-burst ready, which closes the cycle. In the non-burst case the controller opens a new cycle with a fresh address strobe for the next doubleword.

The system can raise a backoff request at any point during a fill. The controller then drops the rest of the cycle and keeps one flag per doubleword it has already received. While the bus is held off it samples external snoops.

A snoop can hit a different line that the cache holds modified. The controller then raises its hit-modified output and runs a four-transfer write-back of that line before it goes back to the fill. A snoop can also hit the line being filled. That line has not been modified, so no write-back is started, and the snoop's invalidate input decides whether the finished line is kept. A fill is resumed with a fresh address strobe on the first doubleword, in burst order, that has not yet been received. The cacheable indication is given only when nothing has been received yet.

Top module: `line_fill_ctl`

## Requirements
- R1: After synchronous active-low reset, `ads`, `hit_mod`, `fill_done` and `last` are all 0.
- R2: The doubleword index driven on `bus_dw` for transfer k (k = 0..3) of a fill that starts at index f is f XOR k. For example, start 1 (offset 4h) gives 1,0,3,2.
- R3: `last` is 1 during the final remaining transfer of a cycle and 0 during the earlier ones.
- R4: A non-burst ready (`nrdy`) accepted before the final transfer is followed in the next cycle by a new `ads` for the next doubleword.
- R5: A ready sampled in the same cycle as `backoff` is ignored. That doubleword is not recorded, and it is requested again on resumption.
- R6: After `backoff` is released, the controller issues a new `ads` one cycle later. The address is the first doubleword, in burst order, that has not yet been received.
- R7: `cacheable` is 1 with an `ads` only when no doubleword of the current fill has been received yet. It is always 0 on a write-back (`bus_write`=1).
- R8: A snoop that hits the line being filled never raises `hit_mod` and never starts a write-back. The fill completes with `fill_kept`=1 if `snoop_inv` was 0 during that snoop, and with `fill_kept`=0 if it was 1.
- R9: A snoop taken during backoff that hits a different line marked modified raises `hit_mod` in the next cycle. After release, a write-back of that line runs before the fill resumes: `bus_write`=1, indices 0,1,2,3, and `last` on the fourth transfer.
- R10: `hit_mod` falls in the cycle after the final write-back ready, so it is 0 at the next fill `ads`.
- R11: No `ads` is driven in the cycle after any cycle in which `backoff` is 1, and a new fill request is not taken while `backoff` is 1.
- R12: `fill_done` is a one-cycle pulse in the cycle after the final ready of a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_req | input | 1 | Start a line fill (taken when idle and not backed off) |
| fill_line | input | LW | Line address of the fill |
| fill_first | input | IDXW | Requested starting doubleword index |
| backoff | input | 1 | Bus backoff request |
| brdy | input | 1 | Burst ready: accept a doubleword, keep the cycle open |
| nrdy | input | 1 | Non-burst ready: accept a doubleword, close the cycle |
| snoop_strobe | input | 1 | External snoop address strobe |
| snoop_line | input | LW | Snooped line address |
| snoop_inv | input | 1 | Snoop requests invalidation |
| snoop_modified | input | 1 | Tag lookup reports the snooped line modified |
| ads | output | 1 | Address strobe |
| bus_line | output | LW | Line address on the bus |
| bus_dw | output | IDXW | Doubleword index on the bus |
| bus_write | output | 1 | Current cycle is a write-back |
| cacheable | output | 1 | Fill is cacheable (valid with ads) |
| last | output | 1 | Final transfer of the cycle |
| hit_mod | output | 1 | Snoop hit a modified line; write-back pending or running |
| fill_done | output | 1 | Fill completed (one-cycle pulse) |
| fill_kept | output | 1 | With fill_done: the line may be validated |

## Verification
The hardest state to reach is a write-back nested inside a fill that is already partly received. To get there, the fill has to be stalled by backoff after some doublewords have arrived. A snoop to another, modified line must then be presented during the held-off window, and the hold must be released only after that snoop. The bench steps through exactly this sequence. It follows the write-back transfer by transfer, and then confirms that hit-modified has fallen and that the fill resumes at the right doubleword without the cacheable indication. A second hard case is backoff and ready arriving together. The bench presents this with both kinds of ready and proves the ignored doubleword through the resume address.

// File: rtl/lff_pkg.sv
// Shared types for the line-fill controller.
// Assumes a line of 2**IDXW doublewords, walked in XOR (interleaved) order.
package lff_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_HOLD = 2'd3
    } bus_st_t;
endpackage

// File: rtl/lff_order.sv
// Picks the next doubleword to request from the start index and the received
// flags, walking the line in interleaved order (start XOR k). Also reports
// when exactly one doubleword remains. Purely combinational.
module lff_order #(
    parameter int IDXW = 2
) (
    input  logic [IDXW-1:0]      first,
    input  logic [(1<<IDXW)-1:0] got,
    output logic [IDXW-1:0]      nxt,
    output logic                 last_one
);
    localparam int NDW = 1 << IDXW;

    // Scan in burst order for the first doubleword not yet received.
    always_comb begin
        logic found;
        found = 1'b0;
        nxt   = first;
        for (int k = 0; k < NDW; k++) begin
            if (!found && !got[first ^ IDXW'(k)]) begin
                nxt   = first ^ IDXW'(k);
                found = 1'b1;
            end
        end
    end

    // One flag left clear means the next transfer is the final one.
    assign last_one = ($countones(got) == NDW - 1);
endmodule

// File: rtl/lff_snoop.sv
// Snoop handling while the bus is held off. A snoop to another, modified line
// raises hit_mod and captures the write-back line. A snoop to the line being
// filled only decides whether that line may be kept. Assumes snoops are
// offered only during backoff and that one write-back is outstanding at most.
module lff_snoop #(
    parameter int LW = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_hold,
    input  logic          backoff,
    input  logic          snoop_strobe,
    input  logic [LW-1:0] snoop_line,
    input  logic          snoop_inv,
    input  logic          snoop_modified,
    input  logic [LW-1:0] fill_line,
    input  logic          fill_start,
    input  logic          wb_last_ack,
    output logic          hit_mod,
    output logic [LW-1:0] wb_line,
    output logic          line_keep
);
    logic take;
    logic same;

    assign same = (snoop_line == fill_line);
    assign take = in_hold && backoff && snoop_strobe && !hit_mod;

    // Hit-modified flag: set by a foreign modified hit, cleared by final write-back ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_mod <= 1'b0;
            wb_line <= '0;
        end else if (wb_last_ack) begin
            hit_mod <= 1'b0;
        end else if (take && !same && snoop_modified) begin
            hit_mod <= 1'b1;
            wb_line <= snoop_line;
        end
    end

    // Keep flag: armed per fill, cleared by an invalidating snoop to that line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_keep <= 1'b0;
        end else if (fill_start) begin
            line_keep <= 1'b1;
        end else if (take && same && snoop_inv) begin
            line_keep <= 1'b0;
        end
    end

    // R9: hit_mod only rises after a snoop strobe
    a_r9_hitm_follows_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_mod) |-> $past(snoop_strobe));

    // R8: a snoop to the line being filled never raises hit_mod
    a_r8_same_line_no_hitm: assert property (@(posedge clk) disable iff (!rst_n)
        (take && same) |=> !hit_mod);
endmodule

// File: rtl/line_fill_ctl.sv
// Line-fill bus controller. Fills one line as 2**IDXW doubleword transfers,
// burst or non-burst, survives backoff by tracking received doublewords,
// and slots in a snoop write-back before resuming. Assumes readies arrive
// only in the data phase and that the data path is handled elsewhere.
module line_fill_ctl
    import lff_pkg::*;
#(
    parameter int LW   = 28,
    parameter int IDXW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fill_req,
    input  logic [LW-1:0]   fill_line,
    input  logic [IDXW-1:0] fill_first,
    input  logic            backoff,
    input  logic            brdy,
    input  logic            nrdy,
    input  logic            snoop_strobe,
    input  logic [LW-1:0]   snoop_line,
    input  logic            snoop_inv,
    input  logic            snoop_modified,
    output logic            ads,
    output logic [LW-1:0]   bus_line,
    output logic [IDXW-1:0] bus_dw,
    output logic            bus_write,
    output logic            cacheable,
    output logic            last,
    output logic            hit_mod,
    output logic            fill_done,
    output logic            fill_kept
);
    localparam int NDW = 1 << IDXW;

    bus_st_t         state;
    logic [LW-1:0]   line_q;
    logic [IDXW-1:0] first_q;
    logic [NDW-1:0]  fill_got;
    logic [NDW-1:0]  wb_got;
    logic            cur_wb;
    logic            done_q;

    logic [IDXW-1:0] act_first;
    logic [NDW-1:0]  act_got;
    logic [IDXW-1:0] nxt_idx;
    logic            last_one;
    logic            ready;
    logic            accept;
    logic            fill_start;
    logic            wb_last_ack;
    logic [LW-1:0]   wb_line;
    logic            line_keep;
    logic            on_bus;

    // Select the cycle in progress: write-back always starts at index 0.
    always_comb begin
        act_first = cur_wb ? '0 : first_q;
        act_got   = cur_wb ? wb_got : fill_got;
    end

    lff_order #(.IDXW(IDXW)) u_order (
        .first    (act_first),
        .got      (act_got),
        .nxt      (nxt_idx),
        .last_one (last_one)
    );

    assign ready       = brdy || nrdy;
    assign accept      = (state == ST_DATA) && !backoff && ready;
    assign fill_start  = (state == ST_IDLE) && fill_req && !backoff;
    assign wb_last_ack = accept && cur_wb && last_one;
    assign on_bus      = (state == ST_ADDR) || (state == ST_DATA);

    lff_snoop #(.LW(LW)) u_snoop (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_hold        (state == ST_HOLD),
        .backoff        (backoff),
        .snoop_strobe   (snoop_strobe),
        .snoop_line     (snoop_line),
        .snoop_inv      (snoop_inv),
        .snoop_modified (snoop_modified),
        .fill_line      (line_q),
        .fill_start     (fill_start),
        .wb_last_ack    (wb_last_ack),
        .hit_mod        (hit_mod),
        .wb_line        (wb_line),
        .line_keep      (line_keep)
    );

    // Bus sequencer: address phase, data phase, held-off wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            line_q   <= '0;
            first_q  <= '0;
            fill_got <= '0;
            wb_got   <= '0;
            cur_wb   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (fill_start) begin
                        line_q   <= fill_line;
                        first_q  <= fill_first;
                        fill_got <= '0;
                        cur_wb   <= 1'b0;
                        state    <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    state <= backoff ? ST_HOLD : ST_DATA;
                end
                ST_DATA: begin
                    if (backoff) begin
                        state <= ST_HOLD;
                    end else if (ready) begin
                        if (cur_wb) wb_got[nxt_idx] <= 1'b1;
                        else        fill_got[nxt_idx] <= 1'b1;
                        if (last_one) begin
                            if (cur_wb) begin
                                wb_got <= '0;
                                cur_wb <= 1'b0;
                                state  <= ST_ADDR;
                            end else begin
                                done_q <= 1'b1;
                                state  <= ST_IDLE;
                            end
                        end else if (nrdy) begin
                            state <= ST_ADDR;
                        end
                    end
                end
                ST_HOLD: begin
                    if (!backoff) begin
                        cur_wb <= hit_mod;
                        state  <= ST_ADDR;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus outputs decoded from the sequencer state.
    always_comb begin
        ads       = (state == ST_ADDR);
        bus_line  = cur_wb ? wb_line : line_q;
        bus_dw    = nxt_idx;
        bus_write = cur_wb && on_bus;
        cacheable = ads && !cur_wb && (fill_got == '0);
        last      = on_bus && last_one;
        fill_done = done_q;
        fill_kept = done_q && line_keep;
    end

    // R11: backoff silences the address strobe in the following cycle
    a_r11_boff_quiets_bus: assert property (@(posedge clk) disable iff (!rst_n)
        backoff |=> !ads);

    // R5: a ready that collides with backoff records nothing
    a_r5_boff_beats_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && backoff) |=> ($stable(fill_got) && $stable(wb_got)));

    // R10: hit_mod is low whenever a fill address strobe goes out
    a_r10_hitm_low_at_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (ads && !bus_write) |-> !hit_mod);

    // R7: a write-back is never marked cacheable
    a_r7_wb_not_cacheable: assert property (@(posedge clk) disable iff (!rst_n)
        bus_write |-> !cacheable);

    // R12: completion is a single-cycle pulse
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> !fill_done);
endmodule

// File: tb/sim_line_fill_ctl.sv
module sim_line_fill_ctl;
    localparam int CLK_P = 10;
    localparam int LW    = 28;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fill_req;
    logic [LW-1:0] fill_line;
    logic [1:0]    fill_first;
    logic          backoff, brdy, nrdy;
    logic          snoop_strobe, snoop_inv, snoop_modified;
    logic [LW-1:0] snoop_line;
    logic          ads, bus_write, cacheable, last, hit_mod, fill_done, fill_kept;
    logic [LW-1:0] bus_line;
    logic [1:0]    bus_dw;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 0;

    // Table: bit2 = burst, bits1:0 = starting doubleword.
    localparam logic [2:0] VEC [8] = '{3'b100, 3'b101, 3'b110, 3'b111,
                                       3'b000, 3'b001, 3'b010, 3'b011};

    line_fill_ctl #(.LW(LW), .IDXW(2)) u0 (
        .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .fill_line(fill_line),
        .fill_first(fill_first), .backoff(backoff), .brdy(brdy), .nrdy(nrdy),
        .snoop_strobe(snoop_strobe), .snoop_line(snoop_line), .snoop_inv(snoop_inv),
        .snoop_modified(snoop_modified), .ads(ads), .bus_line(bus_line),
        .bus_dw(bus_dw), .bus_write(bus_write), .cacheable(cacheable), .last(last),
        .hit_mod(hit_mod), .fill_done(fill_done), .fill_kept(fill_kept)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Data-phase step with burst ready: check index and last, then accept.
    task automatic take_burst(input logic [1:0] dw, input bit lst, input string req);
        chk(bus_dw == dw, req, bus_dw, dw);
        chk(last == lst, "R3", last, lst);
        brdy = 1'b1;
        tick();
        brdy = 1'b0;
    endtask

    task automatic start_fill(input logic [1:0] f, input logic [LW-1:0] ln);
        fill_req = 1'b1; fill_line = ln; fill_first = f;
        tick();
        fill_req = 1'b0;
    endtask

    // One uninterrupted fill, burst or non-burst, checked transfer by transfer.
    task automatic run_fill(input logic [1:0] f, input bit burst, input logic [LW-1:0] ln);
        start_fill(f, ln);
        for (int k = 0; k < 4; k++) begin
            logic [1:0] dw;
            dw = f ^ 2'(k);
            if (k == 0 || !burst) begin
                chk(ads == 1'b1, "R4", ads, 1);
                chk(cacheable == (k == 0), "R7", cacheable, (k == 0));
                chk(bus_line == ln, "R2", bus_line, ln);
                tick();
            end else begin
                chk(ads == 1'b0, "R2", ads, 0);
            end
            chk(bus_dw == dw, "R2", bus_dw, dw);
            chk(last == (k == 3), "R3", last, (k == 3));
            if (burst) brdy = 1'b1; else nrdy = 1'b1;
            tick();
            brdy = 1'b0; nrdy = 1'b0;
        end
        chk(fill_done == 1'b1, "R12", fill_done, 1);
        chk(fill_kept == 1'b1, "R8", fill_kept, 1);
        tick();
        chk(fill_done == 1'b0, "R12", fill_done, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; fill_req = 0; fill_line = '0; fill_first = '0;
        backoff = 0; brdy = 0; nrdy = 0; snoop_strobe = 0; snoop_line = '0;
        snoop_inv = 0; snoop_modified = 0;
        tick(); tick();
        // R1: reset state
        chk(ads == 0, "R1", ads, 0);
        chk(hit_mod == 0, "R1", hit_mod, 0);
        chk(fill_done == 0, "R1", fill_done, 0);
        chk(last == 0, "R1", last, 0);
        rst_n = 1'b1;
        tick();

        // Table walk: every start index, burst and non-burst (R2, R3, R4, R12)
        for (int i = 0; i < 8; i++) run_fill(VEC[i][1:0], VEC[i][2], LW'(28'h100 + i));

        // R5/R6/R7/R8: burst from 1, backoff collides with ready on dw0, same-line snoop inv=0
        start_fill(2'd1, 28'hA0);
        tick();
        take_burst(2'd1, 0, "R2");
        chk(bus_dw == 2'd0, "R2", bus_dw, 0);
        brdy = 1; backoff = 1;
        tick();
        brdy = 0;
        chk(ads == 0, "R11", ads, 0);
        snoop_strobe = 1; snoop_line = 28'hA0; snoop_inv = 0; snoop_modified = 1;
        tick();
        snoop_strobe = 0; snoop_modified = 0;
        chk(hit_mod == 0, "R8", hit_mod, 0);
        backoff = 0;
        tick();
        chk(ads == 1, "R6", ads, 1);
        chk(bus_dw == 2'd0, "R5", bus_dw, 0);
        chk(cacheable == 0, "R7", cacheable, 0);
        chk(bus_write == 0, "R8", bus_write, 0);
        tick();
        take_burst(2'd0, 0, "R6");
        take_burst(2'd3, 0, "R6");
        take_burst(2'd2, 1, "R6");
        chk(fill_done == 1, "R12", fill_done, 1);
        chk(fill_kept == 1, "R8", fill_kept, 1);
        tick();

        // R7: backoff before any data, foreign unmodified snoop -> cacheable resume, no write-back
        start_fill(2'd2, 28'hB0);
        tick();
        backoff = 1;
        tick();
        snoop_strobe = 1; snoop_line = 28'hC5; snoop_modified = 0; snoop_inv = 1;
        tick();
        snoop_strobe = 0; snoop_inv = 0;
        chk(hit_mod == 0, "R9", hit_mod, 0);
        backoff = 0;
        tick();
        chk(ads == 1, "R6", ads, 1);
        chk(cacheable == 1, "R7", cacheable, 1);
        chk(bus_dw == 2'd2, "R6", bus_dw, 2);
        chk(bus_write == 0, "R9", bus_write, 0);
        tick();
        take_burst(2'd2, 0, "R2");
        take_burst(2'd3, 0, "R2");
        take_burst(2'd0, 0, "R2");
        take_burst(2'd1, 1, "R2");
        chk(fill_kept == 1, "R8", fill_kept, 1);
        tick();

        // R8: same-line snoop with invalidate -> fill completes, not kept
        start_fill(2'd0, 28'hD0);
        tick();
        take_burst(2'd0, 0, "R2");
        backoff = 1;
        tick();
        snoop_strobe = 1; snoop_line = 28'hD0; snoop_inv = 1;
        tick();
        snoop_strobe = 0; snoop_inv = 0;
        chk(hit_mod == 0, "R8", hit_mod, 0);
        backoff = 0;
        tick();
        chk(bus_write == 0, "R8", bus_write, 0);
        chk(bus_dw == 2'd1, "R6", bus_dw, 1);
        tick();
        take_burst(2'd1, 0, "R6");
        take_burst(2'd2, 0, "R6");
        take_burst(2'd3, 1, "R6");
        chk(fill_done == 1, "R12", fill_done, 1);
        chk(fill_kept == 0, "R8", fill_kept, 0);
        tick();

        // R9/R10: foreign modified hit -> write-back nested inside a partial fill
        start_fill(2'd3, 28'hE0);
        tick();
        take_burst(2'd3, 0, "R2");
        backoff = 1;
        tick();
        snoop_strobe = 1; snoop_line = 28'hF7; snoop_modified = 1; snoop_inv = 1;
        tick();
        snoop_strobe = 0; snoop_modified = 0; snoop_inv = 0;
        chk(hit_mod == 1, "R9", hit_mod, 1);
        tick();
        chk(ads == 0, "R11", ads, 0);
        backoff = 0;
        tick();
        chk(ads == 1, "R9", ads, 1);
        chk(bus_write == 1, "R9", bus_write, 1);
        chk(bus_line == 28'hF7, "R9", bus_line, 28'hF7);
        chk(cacheable == 0, "R7", cacheable, 0);
        tick();
        for (int j = 0; j < 4; j++) begin
            chk(bus_write == 1, "R9", bus_write, 1);
            take_burst(2'(j), (j == 3), "R9");
        end
        chk(hit_mod == 0, "R10", hit_mod, 0);
        chk(ads == 1, "R10", ads, 1);
        chk(bus_write == 0, "R10", bus_write, 0);
        chk(bus_line == 28'hE0, "R6", bus_line, 28'hE0);
        chk(bus_dw == 2'd2, "R6", bus_dw, 2);
        chk(cacheable == 0, "R7", cacheable, 0);
        tick();
        take_burst(2'd2, 0, "R6");
        take_burst(2'd1, 0, "R6");
        take_burst(2'd0, 1, "R6");
        chk(fill_done == 1, "R12", fill_done, 1);
        chk(fill_kept == 1, "R8", fill_kept, 1);
        tick();

        // R5/R4: non-burst fill, backoff collides with nrdy
        start_fill(2'd1, 28'h55);
        tick();
        nrdy = 1; tick(); nrdy = 0;
        chk(ads == 1, "R4", ads, 1);
        chk(bus_dw == 2'd0, "R4", bus_dw, 0);
        tick();
        nrdy = 1; backoff = 1;
        tick();
        nrdy = 0; backoff = 0;
        chk(ads == 0, "R11", ads, 0);
        tick();
        chk(ads == 1, "R6", ads, 1);
        chk(bus_dw == 2'd0, "R5", bus_dw, 0);
        chk(cacheable == 0, "R7", cacheable, 0);
        for (int k = 0; k < 3; k++) begin
            logic [1:0] dw;
            dw = (k == 0) ? 2'd0 : (k == 1) ? 2'd3 : 2'd2;
            chk(ads == 1, "R4", ads, 1);
            tick();
            chk(bus_dw == dw, "R2", bus_dw, dw);
            chk(last == (k == 2), "R3", last, (k == 2));
            nrdy = 1; tick(); nrdy = 0;
        end
        chk(fill_done == 1, "R12", fill_done, 1);
        tick();

        // R11: a request during backoff is not taken
        backoff = 1;
        fill_req = 1; fill_line = 28'h77; fill_first = 2'd0;
        tick();
        chk(ads == 0, "R11", ads, 0);
        fill_req = 0; backoff = 0;
        tick();
        chk(ads == 0, "R11", ads, 0);

        finish_run();
    end
endmodule